// File: doc/BRIEF.md
# Outstanding-Tag Tracker with Merged Completion Interrupt

This block sits in a storage host controller and records which tagged commands are still in flight. Software marks one or more tags as busy before it sends the matching queued commands. The drive later sends completion frames, and each of these frames can retire any number of tags at once. Setting and clearing come from different owners, so the two sides never need a handshake with each other.

A completion frame has a header word and then a tag-mask word. When the header asks for an interrupt, the block raises one level interrupt for that frame. Any further frames that arrive before software acknowledges the interrupt fold into the same pending interrupt. Beside the busy register, the block keeps an accumulator of the tags retired since the last acknowledge. It also keeps a sticky flag for completion bits that named a tag that was not busy, plus the status and error bytes of the most recent completion frame.

Top module: `atr_active_tags`

## Requirements
- R1: During reset and on the first cycle after it, `active_tags`, `done_tags`, `stray_err`, `irq`, `last_status` and `last_error` are all zero.
- R2: When `sw_set_vld` is high, every bit that is 1 in `sw_set_mask` reads 1 in `active_tags` on the next cycle. No bit of `active_tags` goes from 0 to 1 for any other reason.
- R3: A frame starts with a word that has `rx_sof` high. The frame is a completion frame only if bits 7:0 of that word equal A1h. The next word without `rx_sof` is the tag mask, and bit x of the mask refers to tag x. A frame of any other type changes nothing.
- R4: Each mask bit that is 1 and names a busy tag clears that bit of `active_tags` on the cycle after the mask word.
- R5: A completion frame whose header bit 14 is 1 drives `irq` high on the cycle after its mask word. This holds for exactly one rising edge, however many tags the mask retires.
- R6: A completion frame that arrives while `irq` is already high produces no further rising edge of `irq`.
- R7: `irq_ack` clears `irq`, `done_tags` and `stray_err` on the next cycle. If a mask word arrives in the same cycle, its effects take priority: its tags stand alone in `done_tags` and its interrupt request keeps `irq` high.
- R8: `done_tags` gathers every tag cleared by R4 since the last acknowledge.
- R9: If a software set and a frame clear hit the same bit in the same cycle, the bit ends at 0 if it was 1 before that cycle and at 1 otherwise.
- R10: A mask bit that names a tag which is not busy leaves that tag's `active_tags` bit alone and sets the sticky `stray_err`.
- R11: A completion frame whose header bit 14 is 0 still clears its tags but leaves `irq` unchanged.
- R12: On each mask word, `last_status` takes header bits 23:16 and `last_error` takes header bits 31:24.
- R13: Words without `rx_sof` that follow the mask word are ignored until the next word with `rx_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_set_vld | input | 1 | Software set strobe |
| sw_set_mask | input | NTAGS | Tags to mark busy |
| rx_vld | input | 1 | Received frame word valid |
| rx_sof | input | 1 | Word is the first of a frame |
| rx_word | input | 32 | Received frame word |
| irq_ack | input | 1 | Software interrupt acknowledge |
| irq | output | 1 | Level interrupt |
| active_tags | output | NTAGS | Busy-tag register |
| done_tags | output | NTAGS | Tags retired since the last acknowledge |
| stray_err | output | 1 | Sticky flag for completion of a tag that was not busy |
| last_status | output | 8 | Status byte of the latest completion frame |
| last_error | output | 8 | Error byte of the latest completion frame |

## Verification
The properties assume that frame words arrive in order. A word with `rx_sof` high always opens a frame, and a mask word is meaningful only directly after a matching header. The properties also assume that software may assert a set strobe and an acknowledge in any cycle, including a cycle that carries a mask word. The stimulus keeps to this by sending each frame as a header word followed by a mask word, optionally with trailing words. It lines up set strobes and acknowledges with mask words only in the cases that R7 and R9 cover, and a behavioural model is checked against the design on every cycle.

// File: rtl/atr_pkg.sv
package atr_pkg;
   localparam int            WORD_W    = 32;
   localparam logic [7:0]    COMP_TYPE = 8'hA1;
   localparam int            IBIT_POS  = 14;

   typedef struct packed {
      logic [7:0] err;
      logic [7:0] stat;
      logic       ibit;
   } comp_hdr_t;
endpackage

// File: rtl/atr_frame_parse.sv
module atr_frame_parse
   import atr_pkg::*;
#(
   parameter int NTAGS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_vld,
   input  logic              rx_sof,
   input  logic [WORD_W-1:0] rx_word,
   output logic              comp_vld,
   output logic [NTAGS-1:0]  comp_mask,
   output logic              comp_extra,
   output comp_hdr_t         comp_hdr
);
   logic      armed_q;
   comp_hdr_t hdr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         hdr_q   <= '0;
      end else if (rx_vld) begin
         if (rx_sof) begin
            armed_q    <= (rx_word[7:0] == COMP_TYPE);
            hdr_q.err  <= rx_word[31:24];
            hdr_q.stat <= rx_word[23:16];
            hdr_q.ibit <= rx_word[IBIT_POS];
         end else begin
            armed_q <= 1'b0;
         end
      end
   end

   assign comp_vld  = rx_vld & ~rx_sof & armed_q;
   assign comp_mask = rx_word[NTAGS-1:0];
   assign comp_hdr  = hdr_q;

   generate
      if (NTAGS < WORD_W) begin : g_extra
         assign comp_extra = |rx_word[WORD_W-1:NTAGS];
      end else begin : g_noextra
         assign comp_extra = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/atr_tag_reg.sv
module atr_tag_reg #(
   parameter int NTAGS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_vld,
   input  logic [NTAGS-1:0] set_mask,
   input  logic             clr_vld,
   input  logic [NTAGS-1:0] clr_mask,
   input  logic             ack,
   output logic [NTAGS-1:0] active,
   output logic [NTAGS-1:0] done,
   output logic [NTAGS-1:0] stray
);
   generate
      for (genvar i = 0; i < NTAGS; i++) begin : g_cell
         logic act_r, done_r, set_i, clr_i, hit;
         assign set_i = set_vld & set_mask[i];
         assign clr_i = clr_vld & clr_mask[i];
         assign hit   = clr_i & act_r;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_r  <= 1'b0;
               done_r <= 1'b0;
            end else begin
               if (hit)        act_r <= 1'b0;
               else if (set_i) act_r <= 1'b1;
               if (hit)        done_r <= 1'b1;
               else if (ack)   done_r <= 1'b0;
            end
         end

         assign active[i] = act_r;
         assign done[i]   = done_r;
         assign stray[i]  = clr_i & ~act_r;
      end
   endgenerate
endmodule

// File: rtl/atr_irq_agg.sv
module atr_irq_agg (
   input  logic clk,
   input  logic rst_n,
   input  logic comp_vld,
   input  logic comp_ibit,
   input  logic any_stray,
   input  logic ack,
   output logic irq,
   output logic stray_err
);
   logic irq_q, err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         err_q <= 1'b0;
      end else begin
         if (comp_vld && comp_ibit) irq_q <= 1'b1;
         else if (ack)              irq_q <= 1'b0;
         if (any_stray)             err_q <= 1'b1;
         else if (ack)              err_q <= 1'b0;
      end
   end

   assign irq       = irq_q;
   assign stray_err = err_q;
endmodule

// File: rtl/atr_active_tags.sv
module atr_active_tags
   import atr_pkg::*;
#(
   parameter int NTAGS = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_set_vld,
   input  logic [NTAGS-1:0]  sw_set_mask,
   input  logic              rx_vld,
   input  logic              rx_sof,
   input  logic [WORD_W-1:0] rx_word,
   input  logic              irq_ack,
   output logic              irq,
   output logic [NTAGS-1:0]  active_tags,
   output logic [NTAGS-1:0]  done_tags,
   output logic              stray_err,
   output logic [7:0]        last_status,
   output logic [7:0]        last_error
);
   generate
      if (NTAGS < 1 || NTAGS > WORD_W) begin : g_bad_ntags
         $error("atr_active_tags: NTAGS must lie in 1..32");
      end
   endgenerate

   logic             comp_vld, comp_extra, comp_ibit, any_stray;
   logic [NTAGS-1:0] comp_mask, stray_vec;
   comp_hdr_t        comp_hdr;
   logic [7:0]       stat_q, err_q;

   atr_frame_parse #(.NTAGS(NTAGS)) u_parse (
      .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_sof(rx_sof),
      .rx_word(rx_word), .comp_vld(comp_vld), .comp_mask(comp_mask),
      .comp_extra(comp_extra), .comp_hdr(comp_hdr)
   );

   atr_tag_reg #(.NTAGS(NTAGS)) u_tags (
      .clk(clk), .rst_n(rst_n), .set_vld(sw_set_vld), .set_mask(sw_set_mask),
      .clr_vld(comp_vld), .clr_mask(comp_mask), .ack(irq_ack),
      .active(active_tags), .done(done_tags), .stray(stray_vec)
   );

   assign comp_ibit = comp_hdr.ibit;
   assign any_stray = comp_vld & ((|stray_vec) | comp_extra);

   atr_irq_agg u_irq (
      .clk(clk), .rst_n(rst_n), .comp_vld(comp_vld), .comp_ibit(comp_ibit),
      .any_stray(any_stray), .ack(irq_ack), .irq(irq), .stray_err(stray_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         err_q  <= '0;
      end else if (comp_vld) begin
         stat_q <= comp_hdr.stat;
         err_q  <= comp_hdr.err;
      end
   end

   assign last_status = stat_q;
   assign last_error  = err_q;
endmodule

// File: rtl/atr_active_tags_chk.sv
module atr_active_tags_chk #(
   parameter int NTAGS = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_set_vld,
   input logic [NTAGS-1:0] sw_set_mask,
   input logic             irq_ack,
   input logic             irq,
   input logic [NTAGS-1:0] active_tags,
   input logic [NTAGS-1:0] done_tags,
   input logic             stray_err,
   input logic             comp_vld,
   input logic [NTAGS-1:0] comp_mask,
   input logic             comp_ibit
);
   AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      sw_set_vld && !comp_vld |=> ((active_tags & $past(sw_set_mask)) == $past(sw_set_mask))); // R2

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((active_tags & ~$past(active_tags) & ~($past(sw_set_vld) ? $past(sw_set_mask) : '0)) == '0)); // R2

   AST_CLEAR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      comp_vld && !sw_set_vld |=> ((active_tags & $past(comp_mask)) == '0)); // R4

   AST_IRQ_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(comp_vld && comp_ibit)); // R5

   AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack && !(comp_vld && comp_ibit) |=> !irq); // R7

   AST_ACK_EMPTIES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack && !comp_vld |=> (done_tags == '0)); // R7

   AST_DONE_WAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      ((done_tags & ~$past(done_tags) & ~$past(active_tags)) == '0)); // R8

   AST_STRAY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      comp_vld && ((comp_mask & ~active_tags) != '0) |=> stray_err); // R10
endmodule

bind atr_active_tags atr_active_tags_chk #(.NTAGS(NTAGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .sw_set_vld(sw_set_vld), .sw_set_mask(sw_set_mask),
   .irq_ack(irq_ack), .irq(irq), .active_tags(active_tags), .done_tags(done_tags),
   .stray_err(stray_err), .comp_vld(comp_vld), .comp_mask(comp_mask),
   .comp_ibit(comp_ibit)
);

// File: tb/atr_active_tags_tb_top.sv
`timescale 1ns/1ps
module atr_active_tags_tb_top;
   localparam int NT = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sw_set_vld = 1'b0;
   logic [NT-1:0] sw_set_mask = '0;
   logic          rx_vld = 1'b0;
   logic          rx_sof = 1'b0;
   logic [31:0]   rx_word = '0;
   logic          irq_ack = 1'b0;
   logic          irq, stray_err;
   logic [NT-1:0] active_tags, done_tags;
   logic [7:0]    last_status, last_error;

   always #2 clk = ~clk;

   atr_active_tags #(.NTAGS(NT)) dut_i (
      .clk(clk), .rst_n(rst_n), .sw_set_vld(sw_set_vld), .sw_set_mask(sw_set_mask),
      .rx_vld(rx_vld), .rx_sof(rx_sof), .rx_word(rx_word), .irq_ack(irq_ack),
      .irq(irq), .active_tags(active_tags), .done_tags(done_tags),
      .stray_err(stray_err), .last_status(last_status), .last_error(last_error)
   );

   int n_run = 0, n_fail = 0, rises = 0;
   bit finished = 1'b0;
   bit irq_prev = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   bit [NT-1:0] m_act, m_done;
   bit m_irq, m_err, m_arm, m_hi;
   bit [7:0] m_stat, m_errb, m_hs, m_he;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = '0; m_done = '0; m_irq = 0; m_err = 0; m_arm = 0;
         m_stat = '0; m_errb = '0; m_hs = '0; m_he = '0; m_hi = 0;
      end else begin
         bit comp;
         comp = rx_vld && !rx_sof && m_arm;
         if (irq_ack) begin m_done = '0; m_irq = 0; m_err = 0; end
         for (int i = 0; i < NT; i++) begin
            bit c, s;
            c = comp && rx_word[i];
            s = sw_set_vld && sw_set_mask[i];
            if (c && m_act[i]) begin m_act[i] = 0; m_done[i] = 1; end
            else begin
               if (c) m_err = 1;
               if (s) m_act[i] = 1;
            end
         end
         if (comp) begin
            if (m_hi) m_irq = 1;
            m_stat = m_hs; m_errb = m_he;
         end
         if (rx_vld) begin
            if (rx_sof) begin
               m_arm = (rx_word[7:0] == 8'hA1);
               m_hi = rx_word[14]; m_hs = rx_word[23:16]; m_he = rx_word[31:24];
            end else m_arm = 0;
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (irq && !irq_prev) rises++;
         chk(active_tags == m_act, "R4 active_tags", active_tags, m_act);
         chk(done_tags == m_done, "R8 done_tags", done_tags, m_done);
         chk(irq == m_irq, "R5 irq", irq, m_irq);
         chk(stray_err == m_err, "R10 stray_err", stray_err, m_err);
         chk({last_error, last_status} == {m_errb, m_stat}, "R12 status/error",
             {last_error, last_status}, {m_errb, m_stat});
      end
      irq_prev = irq;
   end

   task automatic set_tags(input logic [NT-1:0] m);
      @(negedge clk); sw_set_vld = 1; sw_set_mask = m;
      @(negedge clk); sw_set_vld = 0; sw_set_mask = '0;
   endtask

   task automatic ack_irq();
      @(negedge clk); irq_ack = 1;
      @(negedge clk); irq_ack = 0;
   endtask

   task automatic send_frame(input logic [7:0] ftype, input bit ibit, input logic [7:0] st,
                             input logic [7:0] er, input logic [NT-1:0] m,
                             input logic [NT-1:0] setm, input int extra, input bit ack_now);
      @(negedge clk);
      rx_vld = 1; rx_sof = 1; rx_word = {er, st, 1'b0, ibit, 6'b0, ftype};
      @(negedge clk);
      rx_sof = 0; rx_word = m;
      sw_set_vld = (setm != '0); sw_set_mask = setm; irq_ack = ack_now;
      for (int k = 0; k < extra; k++) begin
         @(negedge clk);
         sw_set_vld = 0; sw_set_mask = '0; irq_ack = 0; rx_word = 32'hFFFF_FFFF;
      end
      @(negedge clk);
      rx_vld = 0; rx_word = '0; sw_set_vld = 0; sw_set_mask = '0; irq_ack = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(active_tags == 0 && done_tags == 0 && !irq && !stray_err, "R1 in reset",
          {active_tags[29:0], irq, stray_err}, 0);
      rst_n = 1;
      @(negedge clk);
      chk({last_status, last_error} == 0 && active_tags == 0 && !irq, "R1 after reset",
          {last_status, last_error}, 0);

      set_tags(32'h0000_00FF);
      chk(active_tags == 32'h0000_00FF, "R2 first set", active_tags, 32'h0000_00FF);
      set_tags(32'h0001_0000);
      chk(active_tags == 32'h0001_00FF, "R2 second set keeps others", active_tags, 32'h0001_00FF);

      send_frame(8'hA1, 1, 8'h40, 8'h00, 32'h88, '0, 0, 0);
      chk(active_tags == 32'h0001_0077, "R4 tags 3 and 7 cleared", active_tags, 32'h0001_0077);
      chk(irq && rises == 1, "R5 one interrupt for two tags", rises, 1);
      chk(done_tags == 32'h88, "R8 done gathers", done_tags, 32'h88);
      chk(last_status == 8'h40, "R12 status byte", last_status, 8'h40);

      send_frame(8'hA1, 1, 8'h41, 8'h05, 32'h1, '0, 0, 0);
      chk(irq && rises == 1, "R6 merged second frame", rises, 1);
      chk(done_tags == 32'h89, "R8 done after second frame", done_tags, 32'h89);
      chk(last_error == 8'h05, "R12 error byte", last_error, 8'h05);

      ack_irq();
      chk(!irq && done_tags == 0, "R7 acknowledge", {irq, done_tags[30:0]}, 0);

      send_frame(8'h34, 1, 8'h00, 8'h00, 32'hFF, '0, 0, 0);
      chk(active_tags == 32'h0001_0076 && !irq, "R3 foreign frame ignored", active_tags, 32'h0001_0076);

      send_frame(8'hA1, 0, 8'h50, 8'h00, 32'h2, '0, 0, 0);
      chk(active_tags == 32'h0001_0074 && !irq, "R11 no interrupt bit", active_tags, 32'h0001_0074);

      send_frame(8'hA1, 0, 8'h50, 8'h00, 32'h0010_0000, '0, 0, 0);
      chk(stray_err && active_tags == 32'h0001_0074, "R10 stray flagged", active_tags, 32'h0001_0074);
      ack_irq();
      chk(!stray_err, "R7 ack clears stray", stray_err, 0);

      send_frame(8'hA1, 0, 8'h50, 8'h00, 32'h0200_0004, 32'h0200_0004, 0, 0);
      chk(active_tags == 32'h0201_0070, "R9 same-cycle set and clear", active_tags, 32'h0201_0070);
      chk(done_tags == 32'h4 && stray_err, "R9 done and stray", done_tags, 32'h4);

      ack_irq();
      send_frame(8'hA1, 1, 8'h50, 8'h00, 32'h10, '0, 3, 0);
      chk(active_tags == 32'h0201_0060, "R13 trailing words ignored", active_tags, 32'h0201_0060);
      chk(irq && rises == 2 && done_tags == 32'h10, "R5 new interrupt after ack", rises, 2);

      send_frame(8'hA1, 1, 8'h50, 8'h00, 32'h20, '0, 0, 1);
      chk(irq && rises == 2, "R7 frame beats acknowledge", rises, 2);
      chk(done_tags == 32'h20, "R7 done restarts", done_tags, 32'h20);

      ack_irq();
      repeat (2) @(negedge clk);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_run++; n_fail++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule